// File: doc/BRIEF.md
# Priority Interrupt Selector with Threshold

This block picks, for one target context, which interrupt source should be serviced next. Each clock it looks at every source's pending bit, the context's enable bit for that source and the source's priority level. It reports the winning source number and that source's priority. It also drives a request line to the context that is raised only when the winner's priority is above the context's threshold.

The winner is found by a balanced binary tree of two-way compares, so the logic depth is log2 of the source count. The result is registered once, so the outputs follow the inputs sampled at the previous rising clock edge. The reported winner does not depend on the threshold. A later claim step can therefore be given a source that is pending but masked by the threshold. Register storage, bus access and claim/complete handling sit outside this block.

Top module: `irq_prio_select`

## Requirements
- R1: Source number 0 does not exist. Bit 0 of the pending and enable vectors and priority slot 0 are ignored, and `win_id` is never greater than NSRC.
- R2: A source whose priority is 0 is never selected, even when it is pending and enabled.
- R3: A source is eligible only when it is pending, enabled and has non-zero priority. `win_id` names the eligible source with the highest priority, and `win_prio` carries that source's priority.
- R4: When several eligible sources share the highest priority, the one with the smallest number wins.
- R5: `ctx_irq` is 1 exactly when `win_prio` is strictly greater than `ctx_threshold`. A threshold of 0 therefore passes any eligible source, and a winner whose priority equals the threshold gives no request.
- R6: `win_id` and `win_prio` do not depend on `ctx_threshold`. A threshold at the maximum level still reports the winner, with `ctx_irq` at 0.
- R7: When no source is eligible, `win_id` is 0, `win_prio` is 0 and `ctx_irq` is 0.
- R8: The outputs reflect the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, all outputs are 0.
- R9: The maximum priority level (2^PRIO_W-1) and the highest source number NSRC are handled like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the outputs |
| src_pending | input | NSRC+1 | Pending bit per source; bit n is source n, bit 0 ignored |
| src_enable | input | NSRC+1 | Enable bit of this context per source; bit 0 ignored |
| src_prio | input | (NSRC+1)*PRIO_W | Priority of source n in bits [n*PRIO_W +: PRIO_W]; slot 0 ignored |
| ctx_threshold | input | PRIO_W | Priority threshold of the context |
| win_id | output | ID_W | Winning source number, 0 when none is eligible |
| win_prio | output | PRIO_W | Priority of the winner, 0 when none is eligible |
| ctx_irq | output | 1 | Request to the context: winner priority above threshold |

## Verification
A wrong compare in one tree node would either name a source that loses to another eligible source, or pick the higher number in a tie. Either fault shows on `win_id` one cycle after the input pattern that exposes it. A fault in the priority path would show in that same cycle as a `win_prio` that differs from the named source's level, or as a `ctx_irq` that disagrees with the threshold compare. Random patterns mixed with forced ties, sparse eligibility and edge priorities make sure each node sees both sides win.

// File: rtl/prisel_mask.sv
module prisel_mask #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3
) (
    input  logic [NSRC:0]               pend,
    input  logic [NSRC:0]               en,
    input  logic [(NSRC+1)*PRIO_W-1:0]  prio,
    output logic [(NSRC+1)*PRIO_W-1:0]  eff_prio
);
    // Slot 0 is a non-existent source: its inputs are dropped.
    logic unused_slot0;
    assign unused_slot0 = ^{pend[0], en[0], prio[PRIO_W-1:0]};

    assign eff_prio[PRIO_W-1:0] = '0;

    genvar i;
    generate
        for (i = 1; i <= NSRC; i++) begin : g_src
            // A zero level already reads as "not a candidate".
            assign eff_prio[i*PRIO_W +: PRIO_W] =
                (pend[i] && en[i]) ? prio[i*PRIO_W +: PRIO_W] : '0;
        end
    endgenerate
endmodule

// File: rtl/prisel_tree.sv
module prisel_tree #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC + 1)
) (
    input  logic [(NSRC+1)*PRIO_W-1:0] eff_prio,
    output logic [ID_W-1:0]            best_id,
    output logic [PRIO_W-1:0]          best_prio
);
    localparam int LEAVES = 1 << ID_W;
    localparam int NODES  = 2 * LEAVES - 1;

    // Heap layout: node k has children 2k+1 (lower numbers) and 2k+2.
    logic [PRIO_W-1:0] np [NODES];
    logic [ID_W-1:0]   ni [NODES];

    genvar i, k;
    generate
        for (i = 0; i < LEAVES; i++) begin : g_leaf
            if (i <= NSRC) begin : g_real
                assign np[LEAVES-1+i] = eff_prio[i*PRIO_W +: PRIO_W];
            end else begin : g_pad
                assign np[LEAVES-1+i] = '0;
            end
            assign ni[LEAVES-1+i] = ID_W'(i);
        end
        for (k = 0; k < LEAVES - 1; k++) begin : g_node
            logic take_right;
            // The right child wins only when strictly higher, so ties keep the lower number.
            assign take_right = np[2*k+2] > np[2*k+1];
            assign np[k] = take_right ? np[2*k+2] : np[2*k+1];
            assign ni[k] = take_right ? ni[2*k+2] : ni[2*k+1];
        end
    endgenerate

    assign best_prio = np[0];
    assign best_id   = (np[0] == '0) ? '0 : ni[0];
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC:0]              src_pending,
    input  logic [NSRC:0]              src_enable,
    input  logic [(NSRC+1)*PRIO_W-1:0] src_prio,
    input  logic [PRIO_W-1:0]          ctx_threshold,
    output logic [ID_W-1:0]            win_id,
    output logic [PRIO_W-1:0]          win_prio,
    output logic                       ctx_irq
);
    logic [(NSRC+1)*PRIO_W-1:0] eff_prio;
    logic [ID_W-1:0]            best_id;
    logic [PRIO_W-1:0]          best_prio;

    prisel_mask #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_mask (
        .pend     (src_pending),
        .en       (src_enable),
        .prio     (src_prio),
        .eff_prio (eff_prio)
    );

    prisel_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
        .eff_prio  (eff_prio),
        .best_id   (best_id),
        .best_prio (best_prio)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_id   <= '0;
            win_prio <= '0;
            ctx_irq  <= 1'b0;
        end else begin
            win_id   <= best_id;
            win_prio <= best_prio;
            ctx_irq  <= best_prio > ctx_threshold;
        end
    end
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSRC:0]              src_pending,
    input logic [NSRC:0]              src_enable,
    input logic [(NSRC+1)*PRIO_W-1:0] src_prio,
    input logic [PRIO_W-1:0]          ctx_threshold,
    input logic [ID_W-1:0]            win_id,
    input logic [PRIO_W-1:0]          win_prio,
    input logic                       ctx_irq
);
    logic [NSRC:0]              pend_q, en_q;
    logic [(NSRC+1)*PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]          thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            prio_q <= '0;
            thr_q  <= '0;
        end else begin
            pend_q <= src_pending;
            en_q   <= src_enable;
            prio_q <= src_prio;
            thr_q  <= ctx_threshold;
        end
    end

    logic              win_elig;
    logic [PRIO_W-1:0] win_lvl;
    logic              any_better;

    always_comb begin
        win_elig   = 1'b0;
        win_lvl    = '0;
        any_better = 1'b0;
        for (int j = 1; j <= NSRC; j++) begin
            logic [PRIO_W-1:0] lv;
            logic              el;
            lv = prio_q[j*PRIO_W +: PRIO_W];
            el = pend_q[j] && en_q[j] && (lv != '0);
            if (ID_W'(j) == win_id) begin
                win_elig = el;
                win_lvl  = lv;
            end
            if (el && ((lv > win_prio) || ((lv == win_prio) && (ID_W'(j) < win_id) )))
                any_better = 1'b1;
        end
    end

    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_id <= ID_W'(NSRC)); // R1
    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> win_elig); // R2
    AST_WIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> (win_prio == win_lvl)); // R3
    AST_NONE_BETTER: assert property (@(posedge clk) disable iff (!rst_n)
        !any_better); // R4
    AST_REQ_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_irq == (win_prio > thr_q)); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id == '0) |-> ((win_prio == '0) && !ctx_irq)); // R7
endmodule

bind irq_prio_select irq_prio_select_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_pending   (src_pending),
    .src_enable    (src_enable),
    .src_prio      (src_prio),
    .ctx_threshold (ctx_threshold),
    .win_id        (win_id),
    .win_prio      (win_prio),
    .ctx_irq       (ctx_irq)
);

// File: tb/test_irq_prio_select.sv
`timescale 1ns/1ps
module test_irq_prio_select;
    localparam int NSRC   = 31;
    localparam int PRIO_W = 3;
    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int PMAX   = (1 << PRIO_W) - 1;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [NSRC:0]              pend = '0;
    logic [NSRC:0]              en = '0;
    logic [(NSRC+1)*PRIO_W-1:0] prio = '0;
    logic [PRIO_W-1:0]          thr = '0;
    logic [ID_W-1:0]            win_id;
    logic [PRIO_W-1:0]          win_prio;
    logic                       ctx_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_prio_select #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_irq_prio_select (
        .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_enable(en),
        .src_prio(prio), .ctx_threshold(thr),
        .win_id(win_id), .win_prio(win_prio), .ctx_irq(ctx_irq)
    );

    function automatic int ref_id();
        int best = 0;
        int bl = 0;
        for (int j = 1; j <= NSRC; j++) begin
            int lv = int'(prio[j*PRIO_W +: PRIO_W]);
            if (pend[j] && en[j] && lv > bl) begin
                bl = lv;
                best = j;
            end
        end
        return best;
    endfunction

    function automatic int ref_lvl(int id);
        return (id == 0) ? 0 : int'(prio[id*PRIO_W +: PRIO_W]);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_prio(int id, int lv);
        prio[id*PRIO_W +: PRIO_W] = PRIO_W'(lv);
    endtask

    // Inputs are set at a falling edge; results are read one edge later.
    task automatic step_and_check(string req);
        int eid, elv;
        eid = ref_id();
        elv = ref_lvl(eid);
        @(posedge clk);
        @(negedge clk);
        chk({req, " id"}, int'(win_id), eid);
        chk({req, " prio"}, int'(win_prio), elv);
        chk({req, " irq"}, int'(ctx_irq), (elv > int'(thr)) ? 1 : 0);
    endtask

    task automatic clear_all();
        pend = '0; en = '0; prio = '0; thr = '0;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1234_5678);
        // R8: reset holds outputs at zero even with an eligible source present
        pend = '1; en = '1;
        for (int j = 0; j <= NSRC; j++) set_prio(j, 5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset id", int'(win_id), 0);
        chk("R8 reset prio", int'(win_prio), 0);
        chk("R8 reset irq", int'(ctx_irq), 0);
        rst_n = 1'b1;

        // R8: one-cycle latency after reset release
        step_and_check("R8 first");

        // R7: nothing eligible
        clear_all();
        step_and_check("R7 empty");

        // R1: only slot 0 active
        clear_all(); pend[0] = 1'b1; en[0] = 1'b1; set_prio(0, PMAX);
        step_and_check("R1 slot0");
        chk("R1 slot0 id is 0", int'(win_id), 0);

        // R2: pending+enabled but priority 0
        clear_all(); pend[4] = 1'b1; en[4] = 1'b1; set_prio(4, 0);
        pend[9] = 1'b1; en[9] = 1'b1; set_prio(9, 1);
        step_and_check("R2 zero prio");
        chk("R2 picks 9", int'(win_id), 9);

        // R3: disabled source with higher level is skipped
        clear_all(); pend[3] = 1'b1; set_prio(3, 7);
        pend[20] = 1'b1; en[20] = 1'b1; set_prio(20, 2);
        en[15] = 1'b1; set_prio(15, 6);
        step_and_check("R3 masked");
        chk("R3 picks 20", int'(win_id), 20);

        // R4: tie picks lowest number
        clear_all();
        for (int j = 1; j <= NSRC; j++) begin pend[j] = 1'b1; en[j] = 1'b1; set_prio(j, 4); end
        set_prio(1, 3);
        step_and_check("R4 tie");
        chk("R4 picks 2", int'(win_id), 2);

        // R5: equal threshold gives no request; one below does
        thr = 4;
        step_and_check("R5 equal");
        chk("R5 equal irq", int'(ctx_irq), 0);
        thr = 3;
        step_and_check("R5 below");
        chk("R5 below irq", int'(ctx_irq), 1);

        // R6: maximum threshold keeps the winner
        clear_all(); pend[NSRC] = 1'b1; en[NSRC] = 1'b1; set_prio(NSRC, PMAX);
        thr = PMAX;
        step_and_check("R6 max thr");
        chk("R6 id kept", int'(win_id), NSRC);
        chk("R6 prio kept", int'(win_prio), PMAX);

        // R9: highest number with maximum level beats lower numbers below it
        thr = 0;
        pend[1] = 1'b1; en[1] = 1'b1; set_prio(1, PMAX - 1);
        step_and_check("R9 top");
        chk("R9 top id", int'(win_id), NSRC);

        // R3 R4 R5 R6: random patterns with ties and sparse modes
        for (int n = 0; n < 1500; n++) begin
            int mode = n % 3;
            pend = {$urandom(), $urandom()} >> 0;
            en   = NSRC'($urandom());
            if (mode == 1) pend = pend & NSRC'($urandom()) & NSRC'($urandom());
            for (int j = 0; j <= NSRC; j++) begin
                if (mode == 2) set_prio(j, ($urandom() % 2 == 0) ? 0 : 5);
                else set_prio(j, int'($urandom() % (PMAX + 1)));
            end
            thr = PRIO_W'($urandom());
            step_and_check("R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule